// File: doc/BRIEF.md
# Conditional Skip Evaluation Unit

This unit decides, for each test-type instruction, whether the instruction that follows should run or be skipped. The execute stage presents a test code together with the operands that test may need: the accumulator, a memory byte, an immediate, the B pointer, a register value for the decrement form, a bit index and the carry flag. One cycle later the unit returns a result strobe, a skip request, and for the decrement form the new register value with a write strobe.

Some tests are phrased as "run the next instruction if true", so a false outcome raises the skip. Others are phrased as "skip if true". The unit resolves both kinds into one skip flag, so the sequencer needs no knowledge of the phrasing. Fetching operands and suppressing the skipped instruction are left to the surrounding pipeline.

Top module: `cond_skip_unit`

## Requirements
- R1: While rst_n is low at a clock edge, out_valid, skip and dec_write are 0 after that edge.
- R2: A request accepted with in_valid=1 gives out_valid=1 exactly one cycle later, and out_valid=0 otherwise. skip and dec_write are 0 whenever out_valid is 0.
- R3: Test code 0 (accumulator equal) requests a skip exactly when acc differs from mem_op.
- R4: Test code 1 (memory equal immediate) requests a skip exactly when mem_op differs from imm.
- R5: Test code 2 (not equal) requests a skip exactly when acc equals mem_op.
- R6: Test code 3 (greater than) requests a skip exactly when acc is not greater than mem_op, compared as unsigned values.
- R7: Test code 4 (pointer not equal) requests a skip exactly when b_ptr[3:0] equals imm[3:0]. The upper bits of both are ignored.
- R8: Test code 5 (AND immediate) requests a skip exactly when (acc AND imm) is zero.
- R9: Test code 6 (decrement) sets dec_write=1 and dec_value = dec_reg-1 modulo 256. It requests a skip exactly when that value is 0. An input of 0x00 gives 0xFF with no skip. dec_write is 0 for every other code.
- R10: Test code 7 skips when bit bit_idx of acc is 0. Test code 8 skips when bit bit_idx of mem_op is 0. bit_idx 0 is the least significant bit.
- R11: Test code 9 (carry) skips when carry is 0. Test code 10 (no carry) skips when carry is 1.
- R12: Test codes 11 to 15 never request a skip and never set dec_write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | Request strobe |
| test_code | input | 4 | Selects the test |
| acc | input | 8 | Accumulator |
| mem_op | input | 8 | Memory operand |
| imm | input | 8 | Immediate operand |
| b_ptr | input | 8 | B pointer register |
| dec_reg | input | 8 | Register value for the decrement test |
| bit_idx | input | 3 | Bit selector for the bit tests |
| carry | input | 1 | Carry flag |
| out_valid | output | 1 | Result strobe, one cycle after the request |
| skip | output | 1 | Skip the next instruction |
| dec_value | output | 8 | Decremented register value |
| dec_write | output | 1 | dec_value is to be written back |

## Verification
The assertions check on every cycle:
- the one-cycle strobe timing, and that skip and dec_write never appear without out_valid;
- the carry polarity of both carry tests;
- the wrap of a zero register in the decrement test;
- the silence of the unassigned codes.

The outcome of the comparisons, the AND-zero test, the bit selection and the masking of the pointer to its low nibble can only be shown by the bench's scenarios. The bench drives random operands through every code and adds directed cases at equality, at adjacent magnitudes, at bit 0 and bit 7, and at pointers whose upper bits differ.

// File: rtl/skip_pkg.sv
// Package: shared widths and test-code encoding for the skip unit.
// Assumes an 8-bit data path. The pointer nibble width is fixed by the pointer test.
package skip_pkg;
    localparam int DATA_W = 8;
    localparam int PTR_W  = 4;
    localparam int IDX_W  = $clog2(DATA_W);

    typedef enum logic [3:0] {
        TC_EQ_ACC  = 4'd0,
        TC_EQ_MIMM = 4'd1,
        TC_NE_ACC  = 4'd2,
        TC_GT_ACC  = 4'd3,
        TC_PTR_NE  = 4'd4,
        TC_AND_Z   = 4'd5,
        TC_DEC_Z   = 4'd6,
        TC_BIT_ACC = 4'd7,
        TC_BIT_MEM = 4'd8,
        TC_CARRY   = 4'd9,
        TC_NCARRY  = 4'd10
    } test_code_e;
endpackage

// File: rtl/skip_compare.sv
// Module: skip_compare
// Purely combinational magnitude and equality outcomes for the compare-type tests.
// Assumes unsigned operands. The pointer compare uses the low PTR_W bits only.
module skip_compare #(
    parameter int DW = 8,
    parameter int PW = 4
) (
    input  logic [DW-1:0] acc,
    input  logic [DW-1:0] mem_op,
    input  logic [DW-1:0] imm,
    input  logic [DW-1:0] b_ptr,
    output logic          acc_eq_mem,
    output logic          mem_eq_imm,
    output logic          acc_gt_mem,
    output logic          ptr_eq_imm,
    output logic          and_zero
);
    // Compute each relation once so that the selector only routes.
    always_comb begin
        acc_eq_mem = (acc == mem_op);
        mem_eq_imm = (mem_op == imm);
        acc_gt_mem = (acc > mem_op);
        ptr_eq_imm = (b_ptr[PW-1:0] == imm[PW-1:0]);
        and_zero   = ((acc & imm) == '0);
    end
endmodule

// File: rtl/skip_decrement.sv
// Module: skip_decrement
// Decrements a register by one with modulo wrap and flags a zero result.
// Assumes the caller decides whether the result is written back.
module skip_decrement #(
    parameter int DW = 8
) (
    input  logic [DW-1:0] reg_in,
    output logic [DW-1:0] reg_dec,
    output logic          dec_zero
);
    // Wrap is natural: all-zero minus one gives all-ones.
    always_comb begin
        reg_dec  = reg_in - DW'(1);
        dec_zero = (reg_dec == '0);
    end
endmodule

// File: rtl/skip_bit_test.sv
// Module: skip_bit_test
// Selects one bit of a byte by index. Index 0 is the least significant bit.
// Assumes the index width covers the data width exactly.
module skip_bit_test #(
    parameter int DW = 8,
    parameter int IW = 3
) (
    input  logic [DW-1:0] data,
    input  logic [IW-1:0] idx,
    output logic          bit_set
);
    logic [DW-1:0] sel_mask;

    // Build a one-hot mask, one lane per bit position.
    for (genvar g = 0; g < DW; g++) begin : g_lane
        assign sel_mask[g] = (idx == IW'(g));
    end

    // Reduce the masked byte to a single flag.
    always_comb bit_set = |(data & sel_mask);
endmodule

// File: rtl/cond_skip_unit.sv
// Module: cond_skip_unit (top)
// Resolves a test code and its operands into a registered one-cycle skip request.
// The decrement test also returns the new register value.
// Assumes operands are stable with in_valid. Reset is synchronous and active low.
module cond_skip_unit
    import skip_pkg::*;
#(
    parameter int DW = DATA_W,
    parameter int PW = PTR_W,
    parameter int IW = IDX_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          in_valid,
    input  logic [3:0]    test_code,
    input  logic [DW-1:0] acc,
    input  logic [DW-1:0] mem_op,
    input  logic [DW-1:0] imm,
    input  logic [DW-1:0] b_ptr,
    input  logic [DW-1:0] dec_reg,
    input  logic [IW-1:0] bit_idx,
    input  logic          carry,
    output logic          out_valid,
    output logic          skip,
    output logic [DW-1:0] dec_value,
    output logic          dec_write
);
    logic          acc_eq_mem, mem_eq_imm, acc_gt_mem, ptr_eq_imm, and_zero;
    logic [DW-1:0] reg_dec;
    logic          dec_zero;
    logic          acc_bit, mem_bit;
    logic          skip_d, wr_d;

    skip_compare #(.DW(DW), .PW(PW)) u_cmp (
        .acc(acc), .mem_op(mem_op), .imm(imm), .b_ptr(b_ptr),
        .acc_eq_mem(acc_eq_mem), .mem_eq_imm(mem_eq_imm),
        .acc_gt_mem(acc_gt_mem), .ptr_eq_imm(ptr_eq_imm), .and_zero(and_zero)
    );

    skip_decrement #(.DW(DW)) u_dec (
        .reg_in(dec_reg), .reg_dec(reg_dec), .dec_zero(dec_zero)
    );

    skip_bit_test #(.DW(DW), .IW(IW)) u_bit_acc (
        .data(acc), .idx(bit_idx), .bit_set(acc_bit)
    );

    skip_bit_test #(.DW(DW), .IW(IW)) u_bit_mem (
        .data(mem_op), .idx(bit_idx), .bit_set(mem_bit)
    );

    // Map each test to its skip polarity. Execute-if-true tests skip on false.
    always_comb begin
        skip_d = 1'b0;
        wr_d   = 1'b0;
        unique case (test_code)
            TC_EQ_ACC:  skip_d = !acc_eq_mem;
            TC_EQ_MIMM: skip_d = !mem_eq_imm;
            TC_NE_ACC:  skip_d = acc_eq_mem;
            TC_GT_ACC:  skip_d = !acc_gt_mem;
            TC_PTR_NE:  skip_d = ptr_eq_imm;
            TC_AND_Z:   skip_d = and_zero;
            TC_DEC_Z: begin
                skip_d = dec_zero;
                wr_d   = 1'b1;
            end
            TC_BIT_ACC: skip_d = !acc_bit;
            TC_BIT_MEM: skip_d = !mem_bit;
            TC_CARRY:   skip_d = !carry;
            TC_NCARRY:  skip_d = carry;
            default:    skip_d = 1'b0;
        endcase
    end

    // Register the outcome. Flags are gated by the request strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            skip      <= 1'b0;
            dec_write <= 1'b0;
            dec_value <= '0;
        end else begin
            out_valid <= in_valid;
            skip      <= in_valid & skip_d;
            dec_write <= in_valid & wr_d;
            if (in_valid) dec_value <= reg_dec;
        end
    end

    // R2: strobe latency and gating of the flags.
    p_latency_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && rst_n) |=> out_valid);
    p_idle_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !out_valid);
    p_skip_gated_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (skip || dec_write) |-> out_valid);
    // R9: a zero register wraps to all ones and does not skip.
    p_dec_wrap_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && test_code == TC_DEC_Z && dec_reg == '0)
        |=> (dec_write && !skip && dec_value == '1));
    // R11: carry polarity of the two carry tests.
    p_carry_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && test_code == TC_CARRY) |=> (skip == !$past(carry)));
    p_ncarry_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && test_code == TC_NCARRY) |=> (skip == $past(carry)));
    // R12: unassigned codes stay silent.
    p_unassigned_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && test_code > 4'd10) |=> (!skip && !dec_write));
endmodule

// File: tb/tb_cond_skip_unit.sv
`timescale 1ns/1ps
module tb_cond_skip_unit;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       in_valid = 1'b0;
    logic [3:0] test_code = '0;
    logic [7:0] acc = '0, mem_op = '0, imm = '0, b_ptr = '0, dec_reg = '0;
    logic [2:0] bit_idx = '0;
    logic       carry = 1'b0;
    logic       out_valid, skip, dec_write;
    logic [7:0] dec_value;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    always #2.5 clk = ~clk;

    cond_skip_unit dut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .test_code(test_code),
        .acc(acc), .mem_op(mem_op), .imm(imm), .b_ptr(b_ptr), .dec_reg(dec_reg),
        .bit_idx(bit_idx), .carry(carry), .out_valid(out_valid), .skip(skip),
        .dec_value(dec_value), .dec_write(dec_write)
    );

    // Skip outcome expected from the requirements R3 to R12.
    function automatic bit exp_skip(input logic [3:0] c, input logic [7:0] a, m, i, b, d,
                                    input logic [2:0] k, input logic cy);
        case (c)
            4'd0:  return a != m;                    // R3
            4'd1:  return m != i;                    // R4
            4'd2:  return a == m;                    // R5
            4'd3:  return !(a > m);                  // R6
            4'd4:  return b[3:0] == i[3:0];          // R7
            4'd5:  return (a & i) == 8'h00;          // R8
            4'd6:  return d == 8'h01;                // R9
            4'd7:  return a[k] == 1'b0;              // R10
            4'd8:  return m[k] == 1'b0;              // R10
            4'd9:  return cy == 1'b0;                // R11
            4'd10: return cy == 1'b1;                // R11
            default: return 1'b0;                    // R12
        endcase
    endfunction

    function automatic string req_of(input logic [3:0] c);
        case (c)
            4'd0: return "R3"; 4'd1: return "R4"; 4'd2: return "R5"; 4'd3: return "R6";
            4'd4: return "R7"; 4'd5: return "R8"; 4'd6: return "R9";
            4'd7, 4'd8: return "R10"; 4'd9, 4'd10: return "R11";
            default: return "R12";
        endcase
    endfunction

    task automatic check(input string req, input string what, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    // Drive one request at a falling edge; check the result one edge later.
    task automatic run(input logic [3:0] c, input logic [7:0] a, m, i, b, d,
                       input logic [2:0] k, input logic cy);
        bit es;
        @(negedge clk);
        in_valid = 1'b1; test_code = c; acc = a; mem_op = m; imm = i;
        b_ptr = b; dec_reg = d; bit_idx = k; carry = cy;
        es = exp_skip(c, a, m, i, b, d, k, cy);
        @(negedge clk);
        in_valid = 1'b0;
        check("R2", "out_valid", out_valid, 1);
        check(req_of(c), "skip", skip, es);
        check("R9", "dec_write", dec_write, c == 4'd6);
        if (c == 4'd6) check("R9", "dec_value", dec_value, 8'(d - 8'd1));
    endtask

    initial begin
        #100000;
        if (!done) begin
            n_checks++; n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'h5eed_1234));
        repeat (3) @(negedge clk);
        check("R1", "out_valid", out_valid, 0);
        check("R1", "skip", skip, 0);
        check("R1", "dec_write", dec_write, 0);
        @(negedge clk); rst_n = 1'b1;
        @(negedge clk);
        check("R2", "idle out_valid", out_valid, 0);
        check("R2", "idle skip", skip, 0);

        // Directed corner cases.
        run(4'd0, 8'h5A, 8'h5A, 8'h00, 8'h00, 8'h00, 3'd0, 1'b0); // R3 equal
        run(4'd0, 8'h5A, 8'h5B, 8'h00, 8'h00, 8'h00, 3'd0, 1'b0); // R3 differ
        run(4'd1, 8'h00, 8'h33, 8'h33, 8'h00, 8'h00, 3'd0, 1'b0); // R4 equal
        run(4'd1, 8'h00, 8'h33, 8'h32, 8'h00, 8'h00, 3'd0, 1'b0); // R4 differ
        run(4'd2, 8'h80, 8'h80, 8'h00, 8'h00, 8'h00, 3'd0, 1'b0); // R5
        run(4'd3, 8'h80, 8'h7F, 8'h00, 8'h00, 8'h00, 3'd0, 1'b0); // R6 unsigned
        run(4'd3, 8'h40, 8'h40, 8'h00, 8'h00, 8'h00, 3'd0, 1'b0); // R6 equal
        run(4'd3, 8'h3F, 8'h40, 8'h00, 8'h00, 8'h00, 3'd0, 1'b0); // R6 less
        run(4'd4, 8'h00, 8'h00, 8'h07, 8'hF7, 8'h00, 3'd0, 1'b0); // R7 upper ignored
        run(4'd4, 8'h00, 8'h00, 8'hA7, 8'h06, 8'h00, 3'd0, 1'b0); // R7 differ
        run(4'd5, 8'hF0, 8'h00, 8'h0F, 8'h00, 8'h00, 3'd0, 1'b0); // R8 zero
        run(4'd5, 8'hF1, 8'h00, 8'h0F, 8'h00, 8'h00, 3'd0, 1'b0); // R8 nonzero
        run(4'd6, 8'h00, 8'h00, 8'h00, 8'h00, 8'h01, 3'd0, 1'b0); // R9 to zero
        run(4'd6, 8'h00, 8'h00, 8'h00, 8'h00, 8'h00, 3'd0, 1'b0); // R9 wrap
        run(4'd6, 8'h00, 8'h00, 8'h00, 8'h00, 8'h80, 3'd0, 1'b0); // R9 plain
        run(4'd7, 8'h80, 8'h00, 8'h00, 8'h00, 8'h00, 3'd7, 1'b0); // R10 bit 7
        run(4'd7, 8'hFE, 8'h00, 8'h00, 8'h00, 8'h00, 3'd0, 1'b0); // R10 bit 0
        run(4'd8, 8'hFF, 8'h01, 8'h00, 8'h00, 8'h00, 3'd0, 1'b0); // R10 mem
        run(4'd8, 8'hFF, 8'h7F, 8'h00, 8'h00, 8'h00, 3'd7, 1'b0); // R10 mem clear
        run(4'd9, 8'h00, 8'h00, 8'h00, 8'h00, 8'h00, 3'd0, 1'b1); // R11
        run(4'd9, 8'h00, 8'h00, 8'h00, 8'h00, 8'h00, 3'd0, 1'b0); // R11
        run(4'd10, 8'h00, 8'h00, 8'h00, 8'h00, 8'h00, 3'd0, 1'b1); // R11
        run(4'd10, 8'h00, 8'h00, 8'h00, 8'h00, 8'h00, 3'd0, 1'b0); // R11
        run(4'd15, 8'h00, 8'hFF, 8'h00, 8'h00, 8'h01, 3'd0, 1'b0); // R12

        // Random requests over all codes, with some operands forced equal.
        for (int n = 0; n < 600; n++) begin
            logic [7:0] ra, rm, ri, rb, rd;
            ra = 8'($urandom); rm = 8'($urandom); ri = 8'($urandom);
            rb = 8'($urandom); rd = 8'($urandom);
            if ($urandom_range(3) == 0) rm = ra;
            if ($urandom_range(3) == 0) ri = rm;
            if ($urandom_range(3) == 0) rd = 8'($urandom_range(1));
            run(4'($urandom_range(15)), ra, rm, ri, rb, rd, 3'($urandom), 1'($urandom));
        end

        @(negedge clk);
        check("R2", "tail out_valid", out_valid, 0);
        done = 1'b1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
        $finish;
    end
endmodule